// File: doc/BRIEF.md
# Monochrome Glyph Span Expander

This block draws one row segment of a 1-bit bitmap into an 8-bit-per-pixel frame buffer. The host first loads the drawing state through a small register write port: foreground and background colors, a plane mask, a row number, a first and a last column, and two step values. Writing a 32-bit bitmap word then starts a span. The engine walks the columns from the first to the last, one pixel write per cycle. Each pixel takes the foreground color where its bitmap bit is 1 and the background color where it is 0.

Pixel writes leave through a valid/ready port that carries a linear address (row times the line pitch, plus the column), the color and the plane mask. Whenever a word starts a span, the column and row registers advance by their step values. A glyph row wider than 32 pixels is therefore drawn by writing consecutive words, with no new coordinates in between. All span state is copied when the span starts, so the host may load the next setup while the current span is still being drawn.

Top module: `glyph_span_engine`

## Requirements
- R1: After a synchronous reset, `busy` and `px_valid` are 0 and `wr_ready` is 1. The colors, row, columns and steps reset to 0 and the plane mask resets to 0xFF.
- R2: `wr_sel` selects the target of a write: 0 foreground, 1 background, 2 plane mask (colors and mask in `wr_data[7:0]`), 3 row, 4 first column, 5 last column, 6 column step, 7 row step (these in `wr_data[11:0]`), 8 bitmap word. An accepted bitmap word with a non-empty range raises `px_valid` in the following cycle, carrying the first pixel.
- R3: Bitmap bit 31 colors the first column and each lower bit colors the next higher column; pixels are issued in increasing column order.
- R4: A 1 bit produces the foreground color on `px_data` and a 0 bit produces the background color.
- R5: A span covers the first through the last column inclusive. When that range is wider than 32 pixels, only the 32 pixels starting at the first column are written.
- R6: `px_addr` equals row × PITCH + column.
- R7: `px_mask` carries the plane mask that was in force when the span started.
- R8: While `px_valid` is high and `px_ready` is low, `px_valid`, `px_addr`, `px_data` and `px_mask` hold their values into the next cycle.
- R9: `busy` and `px_valid` are high from the cycle after the start until the cycle after the last pixel is accepted. A bitmap word offered while `busy` is high sees `wr_ready` low and is dropped.
- R10: A bitmap word whose last column is less than its first column writes no pixels, leaves `busy` low, and leaves the column and row registers unchanged.
- R11: Each span that starts adds the column step to both column registers and the row step to the row register, modulo 2^12.
- R12: Setup writes made while a span is being drawn do not change that span. They apply from the next bitmap word on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 4 | Write target select |
| wr_data | input | 32 | Write data |
| wr_ready | output | 1 | Low when a bitmap word cannot be taken |
| busy | output | 1 | Span in progress |
| px_valid | output | 1 | Pixel write offered |
| px_ready | input | 1 | Frame buffer accepts the pixel write |
| px_addr | output | 24 | Linear pixel address |
| px_data | output | 8 | Pixel color |
| px_mask | output | 8 | Plane mask for the write |

## Verification
The bench goes after the span edges. It draws one-pixel spans, a span of exactly 32 pixels and one far wider than 32. A design with an off-by-one in the inclusive range or in the clamp would emit a missing or extra pixel, and the queue of expected writes would then run dry or be left over. Random back-pressure on `px_ready` exposes an engine that advances or alters its outputs on a stalled beat, which would skip columns or shift the bit-to-column mapping. Three further cases are a reversed range, which a faulty design would draw as a huge span or would use to step the registers; a bitmap word offered while busy, which must not be taken; and colors changed mid-span, which a design that does not copy its state at start would apply to pixels already under way.

// File: rtl/glyph_pkg.sv
package glyph_pkg;

    localparam int PIX_W     = 8;
    localparam int WORD_BITS = 32;
    localparam int CNT_W     = $clog2(WORD_BITS);

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic [3:0] {
        SEL_FG    = 4'd0,
        SEL_BG    = 4'd1,
        SEL_MASK  = 4'd2,
        SEL_ROW   = 4'd3,
        SEL_XFST  = 4'd4,
        SEL_XLST  = 4'd5,
        SEL_XSTEP = 4'd6,
        SEL_YSTEP = 4'd7,
        SEL_BITS  = 4'd8
    } reg_sel_e;

    function automatic pix_t color_pick(input logic bit_v, input pix_t fg, input pix_t bg);
        return bit_v ? fg : bg;
    endfunction

endpackage

// File: rtl/glyph_setup_regs.sv
module glyph_setup_regs
    import glyph_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [3:0]    wr_sel,
    input  logic [31:0]   wr_data,
    input  logic          busy,
    output logic          wr_ready,
    output logic          launch,
    output pix_t          fg,
    output pix_t          bg,
    output pix_t          mask,
    output logic [CW-1:0] row,
    output logic [CW-1:0] x_first,
    output logic [CW-1:0] x_last
);

    logic [CW-1:0] x_step, y_step;
    logic          take_bits;
    logic          range_ok;

    assign wr_ready  = !busy;
    assign take_bits = wr_en && (wr_sel == SEL_BITS) && wr_ready;
    assign range_ok  = (x_last >= x_first);
    assign launch    = take_bits && range_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            fg      <= '0;
            bg      <= '0;
            mask    <= '1;
            row     <= '0;
            x_first <= '0;
            x_last  <= '0;
            x_step  <= '0;
            y_step  <= '0;
        end else if (launch) begin
            x_first <= x_first + x_step;
            x_last  <= x_last + x_step;
            row     <= row + y_step;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_FG:    fg      <= wr_data[PIX_W-1:0];
                SEL_BG:    bg      <= wr_data[PIX_W-1:0];
                SEL_MASK:  mask    <= wr_data[PIX_W-1:0];
                SEL_ROW:   row     <= wr_data[CW-1:0];
                SEL_XFST:  x_first <= wr_data[CW-1:0];
                SEL_XLST:  x_last  <= wr_data[CW-1:0];
                SEL_XSTEP: x_step  <= wr_data[CW-1:0];
                SEL_YSTEP: y_step  <= wr_data[CW-1:0];
                default: ;
            endcase
        end
    end

    // R11: both columns and the row move by their steps on each start
    a_r11_step: assert property (@(posedge clk) disable iff (rst)
        launch |=> (x_first == CW'($past(x_first) + $past(x_step))) &&
                   (x_last  == CW'($past(x_last)  + $past(x_step))) &&
                   (row     == CW'($past(row)     + $past(y_step))));

endmodule

// File: rtl/glyph_span_walker.sv
module glyph_span_walker
    import glyph_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic [31:0]   bits_in,
    input  pix_t          fg_in,
    input  pix_t          bg_in,
    input  pix_t          mask_in,
    input  logic [CW-1:0] row_in,
    input  logic [CW-1:0] x_first_in,
    input  logic [CW-1:0] x_last_in,
    input  logic          px_ready,
    output logic          busy,
    output logic          cur_bit,
    output logic [CW-1:0] cur_x,
    output logic [CW-1:0] cur_y,
    output pix_t          cur_fg,
    output pix_t          cur_bg,
    output pix_t          cur_mask
);

    typedef struct packed {
        logic [WORD_BITS-1:0] bits;
        logic [CNT_W-1:0]     left;
        logic [CW-1:0]        x;
        logic [CW-1:0]        y;
        pix_t                 fg;
        pix_t                 bg;
        pix_t                 mask;
    } span_t;

    span_t          sp;
    logic [CW-1:0]  diff;
    logic [CNT_W-1:0] last_idx;
    logic           beat_done;

    assign diff      = x_last_in - x_first_in;
    assign last_idx  = (diff > CW'(WORD_BITS - 1)) ? CNT_W'(WORD_BITS - 1) : diff[CNT_W-1:0];
    assign beat_done = busy && px_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sp   <= '0;
        end else if (launch) begin
            busy    <= 1'b1;
            sp.bits <= bits_in;
            sp.left <= last_idx;
            sp.x    <= x_first_in;
            sp.y    <= row_in;
            sp.fg   <= fg_in;
            sp.bg   <= bg_in;
            sp.mask <= mask_in;
        end else if (beat_done) begin
            if (sp.left == '0) begin
                busy <= 1'b0;
            end else begin
                sp.bits <= {sp.bits[WORD_BITS-2:0], 1'b0};
                sp.x    <= sp.x + 1'b1;
                sp.left <= sp.left - 1'b1;
            end
        end
    end

    assign cur_bit  = sp.bits[WORD_BITS-1];
    assign cur_x    = sp.x;
    assign cur_y    = sp.y;
    assign cur_fg   = sp.fg;
    assign cur_bg   = sp.bg;
    assign cur_mask = sp.mask;

    // R1: reset clears the span engine
    a_r1_idle_after_reset: assert property (@(posedge clk) rst |=> !busy);

    // R9: a stalled beat never ends the span
    a_r9_stall_keeps_busy: assert property (@(posedge clk) disable iff (rst)
        busy && !px_ready |=> busy);

    // R3: an accepted non-final beat moves to the next column
    a_r3_next_column: assert property (@(posedge clk) disable iff (rst)
        busy && px_ready && (sp.left != '0) |=> cur_x == CW'($past(cur_x) + 1'b1));

endmodule

// File: rtl/glyph_pixel_out.sv
module glyph_pixel_out
    import glyph_pkg::*;
#(
    parameter int CW    = 12,
    parameter int AW    = 24,
    parameter int PITCH = 1024
) (
    input  logic          bit_v,
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    input  pix_t          fg,
    input  pix_t          bg,
    output logic [AW-1:0] addr,
    output pix_t          data
);

    localparam logic [AW-1:0] PITCH_A = AW'(PITCH);

    assign addr = AW'(y) * PITCH_A + AW'(x);
    assign data = color_pick(bit_v, fg, bg);

endmodule

// File: rtl/glyph_span_engine.sv
module glyph_span_engine
    import glyph_pkg::*;
#(
    parameter int CW    = 12,
    parameter int AW    = 24,
    parameter int PITCH = 1024
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [3:0]           wr_sel,
    input  logic [31:0]          wr_data,
    output logic                 wr_ready,
    output logic                 busy,
    output logic                 px_valid,
    input  logic                 px_ready,
    output logic [AW-1:0]        px_addr,
    output logic [PIX_W-1:0]     px_data,
    output logic [PIX_W-1:0]     px_mask
);

    logic          launch;
    pix_t          fg, bg, mask;
    logic [CW-1:0] row, x_first, x_last;
    logic          cur_bit;
    logic [CW-1:0] cur_x, cur_y;
    pix_t          cur_fg, cur_bg, cur_mask;

    glyph_setup_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .busy(busy), .wr_ready(wr_ready), .launch(launch),
        .fg(fg), .bg(bg), .mask(mask),
        .row(row), .x_first(x_first), .x_last(x_last)
    );

    glyph_span_walker #(.CW(CW)) u_walk (
        .clk(clk), .rst(rst),
        .launch(launch), .bits_in(wr_data),
        .fg_in(fg), .bg_in(bg), .mask_in(mask),
        .row_in(row), .x_first_in(x_first), .x_last_in(x_last),
        .px_ready(px_ready), .busy(busy),
        .cur_bit(cur_bit), .cur_x(cur_x), .cur_y(cur_y),
        .cur_fg(cur_fg), .cur_bg(cur_bg), .cur_mask(cur_mask)
    );

    glyph_pixel_out #(.CW(CW), .AW(AW), .PITCH(PITCH)) u_out (
        .bit_v(cur_bit), .x(cur_x), .y(cur_y),
        .fg(cur_fg), .bg(cur_bg),
        .addr(px_addr), .data(px_data)
    );

    assign px_valid = busy;
    assign px_mask  = cur_mask;

    // R8: a stalled pixel write holds all its fields
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        px_valid && !px_ready |=> px_valid && $stable(px_addr) &&
                                  $stable(px_data) && $stable(px_mask));

    // R10: a reversed range never starts a span
    a_r10_reversed_idle: assert property (@(posedge clk) disable iff (rst)
        wr_en && (wr_sel == SEL_BITS) && wr_ready && (x_last < x_first) |=> !busy);

    // R2: an accepted non-empty word starts a span in the next cycle
    a_r2_start: assert property (@(posedge clk) disable iff (rst)
        wr_en && (wr_sel == SEL_BITS) && wr_ready && (x_last >= x_first) |=> px_valid);

endmodule

// File: tb/glyph_span_engine_tb.sv
module glyph_span_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CW    = 12;
    localparam int AW    = 24;
    localparam int PITCH = 1024;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_sel = '0;
    logic [31:0]   wr_data = '0;
    logic          wr_ready, busy, px_valid;
    logic          px_ready = 1'b1;
    logic [AW-1:0] px_addr;
    logic [7:0]    px_data, px_mask;

    glyph_span_engine #(.CW(CW), .AW(AW), .PITCH(PITCH)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .wr_ready(wr_ready), .busy(busy), .px_valid(px_valid), .px_ready(px_ready),
        .px_addr(px_addr), .px_data(px_data), .px_mask(px_mask)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit rand_ready = 1'b0;
    bit done = 1'b0;

    // reference model state
    int m_fg = 0, m_bg = 0, m_mask = 255, m_row = 0, m_xs = 0, m_xe = 0;
    int m_xstep = 0, m_ystep = 0;
    int q_addr[$], q_data[$], q_mask[$];

    bit   prev_stall = 1'b0;
    logic [AW-1:0] prev_addr;
    logic [7:0]    prev_data, prev_mask;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_write(input int sel, input int data, input bit ready);
        case (sel)
            0: m_fg    = data & 255;
            1: m_bg    = data & 255;
            2: m_mask  = data & 255;
            3: m_row   = data & 4095;
            4: m_xs    = data & 4095;
            5: m_xe    = data & 4095;
            6: m_xstep = data & 4095;
            7: m_ystep = data & 4095;
            8: if (ready && m_xe >= m_xs) begin
                int n;
                n = m_xe - m_xs + 1;
                if (n > 32) n = 32;
                for (int i = 0; i < n; i++) begin
                    int b;
                    b = (data >> (31 - i)) & 1;
                    q_addr.push_back(m_row * PITCH + m_xs + i);
                    q_data.push_back(b ? m_fg : m_bg);
                    q_mask.push_back(m_mask);
                end
                m_xs  = (m_xs + m_xstep) & 4095;
                m_xe  = (m_xe + m_xstep) & 4095;
                m_row = (m_row + m_ystep) & 4095;
            end
            default: ;
        endcase
    endfunction

    // one write; entered and left at posedge + 1
    task automatic wr(input int sel, input int data);
        wr_en = 1'b1; wr_sel = 4'(sel); wr_data = data;
        model_write(sel, data, wr_ready);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic word(input int data);
        while (!wr_ready) begin @(posedge clk); #1; end
        wr(8, data);
    endtask

    task automatic drain();
        while (q_addr.size() > 0 || busy) begin @(posedge clk); #1; end
        @(posedge clk); #1;
    endtask

    task automatic span(input int row, input int xs, input int xe);
        wr(3, row); wr(4, xs); wr(5, xe);
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit launching, exp_busy;
            px_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
            launching = wr_en && (wr_sel == 4'd8) && wr_ready;
            exp_busy  = (q_addr.size() > 0) && !launching;
            chk(busy == exp_busy && px_valid == exp_busy, "R9 busy/valid", {busy, px_valid}, {exp_busy, exp_busy});
            if (px_valid && prev_stall)
                chk(px_addr == prev_addr && px_data == prev_data && px_mask == prev_mask,
                    "R8 hold", px_addr, prev_addr);
            if (px_valid && px_ready) begin
                if (q_addr.size() == 0) begin
                    chk(1'b0, "R2 R5 unexpected pixel", px_addr, 0);
                end else begin
                    int ea, ed, em;
                    ea = q_addr.pop_front(); ed = q_data.pop_front(); em = q_mask.pop_front();
                    chk(px_addr == AW'(ea), "R3 R5 R6 addr", px_addr, ea);
                    chk(px_data == 8'(ed), "R4 data", px_data, ed);
                    chk(px_mask == 8'(em), "R7 mask", px_mask, em);
                end
            end
            prev_stall = px_valid && !px_ready;
            prev_addr = px_addr; prev_data = px_data; prev_mask = px_mask;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(px_valid == 1'b0, "R1 px_valid", px_valid, 0);
        chk(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);

        // R1 register defaults: one pixel at column 0, row 0, mask 0xFF, bg 0
        word(32'h0000_0000);
        drain();

        // R2 R3 R4: full 32-pixel span
        wr(0, 8'hA5); wr(1, 8'h3C);
        span(5, 10, 41);
        word(32'hF0F0_1234);
        drain();

        // R8: random back-pressure, partial spans
        rand_ready = 1'b1;
        span(9, 100, 107); word(32'hA500_0000); drain();
        span(9, 300, 300); word(32'h8000_0000); drain();
        span(11, 4000, 4012); word(32'h5A5A_FFFF); drain();

        // R11: column stepping for row-wise glyph drawing
        wr(6, 32); wr(7, 0);
        span(7, 0, 31);
        word(32'h1234_5678); word(32'h9ABC_DEF0); word(32'hFFFF_0000);
        drain();
        wr(6, 0); wr(7, 1);
        span(20, 64, 71);
        word(32'hC300_0000); word(32'h3C00_0000);
        drain();

        // R5: range wider than 32 clamps
        wr(7, 0);
        span(30, 200, 300); word(32'h8000_0001); drain();

        // R10: reversed range does nothing and does not step
        wr(6, 5);
        span(40, 50, 49);
        word(32'hFFFF_FFFF);
        repeat (3) begin
            chk(busy == 1'b0 && px_valid == 1'b0, "R10 idle", busy, 0);
            @(posedge clk); #1;
        end
        wr(5, 52);
        word(32'hE000_0000);   // columns 50..52 expected, unstepped start
        drain();

        // R9 hold-off and R12 snapshot
        wr(6, 0);
        span(50, 500, 531);
        word(32'hAAAA_5555);
        chk(wr_ready == 1'b0, "R9 wr_ready low while busy", wr_ready, 0);
        wr(8, 32'hFFFF_FFFF);  // dropped
        wr(0, 8'h11); wr(1, 8'h22); wr(2, 8'h0F);  // R12 applies to next word only
        drain();
        // R7: new mask applied
        span(51, 600, 615); word(32'hFF00_F0F0); drain();

        rand_ready = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk(q_addr.size() == 0, "R5 leftover expected pixels", q_addr.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule